// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter with Selectable Parity

This block takes one parallel character and shifts it out on a single serial line. Each frame has a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The data width is 7 or 8 bits. The parity slot can carry even parity, odd parity, a constant 1 (mark), a constant 0 (space), or it can be left out. When nothing is being sent, the line rests high.

A character arrives over a valid/ready handshake. When the handshake completes, the block captures the character and the configuration inputs, so the configuration may change freely during a frame. An external single-cycle baud tick paces every bit. The block has no rate generator of its own. Bit boundaries fall only on ticks, so every bit on the line lasts exactly one tick interval. This includes the start bit, which waits for the first tick after acceptance.

Top module: `sertx_framer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txLine` is 1 and `chrReady` is 1. Ticks that arrive while idle leave the line high.
- R2: `chrReady` is 1 only while idle. A character is taken at a clock edge where `chrValid` and `chrReady` are both 1. `chrReady` is then 0 until the tick that ends the last stop bit. `chrData`, `cfgWide`, `cfgParity` and `cfgTwoStop` are captured at acceptance, and later changes to them do not affect the frame in flight.
- R3: The line goes low for the start bit at the first `baudTick` after acceptance. A tick in the acceptance cycle itself is not counted, and the line stays high after it.
- R4: The data bits follow the start bit least significant bit first. `txLine` changes only at clock edges where `baudTick` is 1, one bit per tick.
- R5: With `cfgWide`=0 the frame carries data bits 0..6 only, and `chrData[7]` affects neither the data nor the parity. With `cfgWide`=1 it carries bits 0..7.
- R6: `cfgParity`=1 (even): the parity bit is the XOR of the sent data bits.
- R7: `cfgParity`=2 (odd): the parity bit is the inverted XOR of the sent data bits.
- R8: `cfgParity`=3 (mark): the parity bit is 1 for any data.
- R9: `cfgParity`=4 (space): the parity bit is 0 for any data.
- R10: `cfgParity`=0 (none, and also the unused codes 5 to 7): there is no parity slot, and the stop bit directly follows the last data bit.
- R11: After the parity slot (or the last data bit) the line is high for one stop bit when `cfgTwoStop`=0, and for two when `cfgTwoStop`=1. The tick that ends the final stop bit returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle pulse marking each bit boundary |
| chrValid | input | 1 | Character offered |
| chrReady | output | 1 | Block idle, character will be taken |
| chrData | input | 8 | Character, bit 0 sent first |
| cfgWide | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfgParity | input | 3 | 0 none, 1 even, 2 odd, 3 mark, 4 space |
| cfgTwoStop | input | 1 | 1 = two stop bits |
| txLine | output | 1 | Serial output, idles high |

## Verification
Two events can land in the same clock cycle. One is a baud tick arriving together with the handshake that accepts a character. The other is the tick that ends a frame arriving right before the next character is offered. The bench drives some frames with the tick raised in the acceptance cycle and checks that the line stays high and that the start bit waits for the following tick. It also offers the next character one cycle after the closing tick, and checks that ready is high at that point and that the new frame is framed correctly. Between ticks, random gaps of zero to two cycles confirm that the line moves only on ticks.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } parMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_e;

  // Strobes from control to datapath; at most one drive strobe per cycle.
  typedef struct packed {
    logic load;
    logic sendStart;
    logic sendData;
    logic sendParity;
    logic sendMark;
  } txStrobe_t;

  function automatic logic parityUsed(input logic [2:0] mode);
    return (mode == PAR_EVEN) || (mode == PAR_ODD) ||
           (mode == PAR_MARK) || (mode == PAR_SPACE);
  endfunction

endpackage

// File: rtl/sertx_ctrl.sv
`timescale 1ns/1ps
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic             chrValid,
  input  logic             cfgWide,
  input  logic [2:0]       cfgParity,
  input  logic             cfgTwoStop,
  output logic             chrReady,
  output txStrobe_t        strobe
);

  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(DATA_W - 2);

  txState_e        stateQ, stateD;
  logic [CNT_W-1:0] bitCntQ, bitCntD;
  logic            wideQ, parOnQ, twoStopQ;
  logic            secondStopQ, secondStopD;
  logic [CNT_W-1:0] lastIdx;

  assign lastIdx  = wideQ ? LAST_WIDE : LAST_NARROW;
  assign chrReady = (stateQ == ST_IDLE);

  always_comb begin
    stateD      = stateQ;
    bitCntD     = bitCntQ;
    secondStopD = secondStopQ;
    strobe      = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (chrValid) begin
          strobe.load = 1'b1;
          stateD      = ST_ARM;
        end
      end
      ST_ARM: begin
        if (baudTick) begin
          strobe.sendStart = 1'b1;
          stateD           = ST_START;
        end
      end
      ST_START: begin
        if (baudTick) begin
          strobe.sendData = 1'b1;
          bitCntD         = '0;
          stateD          = ST_DATA;
        end
      end
      ST_DATA: begin
        if (baudTick) begin
          if (bitCntQ == lastIdx) begin
            secondStopD = 1'b0;
            if (parOnQ) begin
              strobe.sendParity = 1'b1;
              stateD            = ST_PARITY;
            end else begin
              strobe.sendMark = 1'b1;
              stateD          = ST_STOP;
            end
          end else begin
            strobe.sendData = 1'b1;
            bitCntD         = bitCntQ + 1'b1;
          end
        end
      end
      ST_PARITY: begin
        if (baudTick) begin
          strobe.sendMark = 1'b1;
          secondStopD     = 1'b0;
          stateD          = ST_STOP;
        end
      end
      ST_STOP: begin
        if (baudTick) begin
          strobe.sendMark = 1'b1;
          if (twoStopQ && !secondStopQ) begin
            secondStopD = 1'b1;
          end else begin
            stateD = ST_IDLE;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      bitCntQ     <= '0;
      secondStopQ <= 1'b0;
      wideQ       <= 1'b1;
      parOnQ      <= 1'b0;
      twoStopQ    <= 1'b0;
    end else begin
      stateQ      <= stateD;
      bitCntQ     <= bitCntD;
      secondStopQ <= secondStopD;
      if (strobe.load) begin
        wideQ    <= cfgWide;
        parOnQ   <= parityUsed(cfgParity);
        twoStopQ <= cfgTwoStop;
      end
    end
  end

endmodule

// File: rtl/sertx_dpath.sv
`timescale 1ns/1ps
module sertx_dpath
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] chrData,
  input  logic              cfgWide,
  input  logic [2:0]        cfgParity,
  output logic              txLine
);

  localparam int NARROW_W = DATA_W - 1;

  logic [DATA_W-1:0] shiftQ;
  logic [DATA_W-1:0] dataMasked;
  logic              parQ;
  logic              lineQ;
  logic              dataXor;
  logic              parNext;

  // The top data bit is zeroed in narrow mode so that it reaches neither the line nor the parity.
  assign dataMasked = cfgWide ? chrData : {1'b0, chrData[NARROW_W-1:0]};
  assign dataXor    = ^dataMasked;

  always_comb begin
    unique case (cfgParity)
      PAR_EVEN:  parNext = dataXor;
      PAR_ODD:   parNext = ~dataXor;
      PAR_MARK:  parNext = 1'b1;
      default:   parNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      parQ   <= 1'b0;
      lineQ  <= 1'b1;
    end else begin
      if (strobe.load) begin
        shiftQ <= dataMasked;
        parQ   <= parNext;
      end
      if (strobe.sendStart) begin
        lineQ <= 1'b0;
      end else if (strobe.sendData) begin
        lineQ  <= shiftQ[0];
        shiftQ <= shiftQ >> 1;
      end else if (strobe.sendParity) begin
        lineQ <= parQ;
      end else if (strobe.sendMark) begin
        lineQ <= 1'b1;
      end
    end
  end

  assign txLine = lineQ;

endmodule

// File: rtl/sertx_framer.sv
`timescale 1ns/1ps
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              chrValid,
  output logic              chrReady,
  input  logic [DATA_W-1:0] chrData,
  input  logic              cfgWide,
  input  logic [2:0]        cfgParity,
  input  logic              cfgTwoStop,
  output logic              txLine
);

  txStrobe_t strobe;

  sertx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .baudTick   (baudTick),
    .chrValid   (chrValid),
    .cfgWide    (cfgWide),
    .cfgParity  (cfgParity),
    .cfgTwoStop (cfgTwoStop),
    .chrReady   (chrReady),
    .strobe     (strobe)
  );

  sertx_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .chrData   (chrData),
    .cfgWide   (cfgWide),
    .cfgParity (cfgParity),
    .txLine    (txLine)
  );

endmodule

// File: rtl/sertx_framer_chk.sv
`timescale 1ns/1ps
module sertx_framer_chk (
  input logic clk,
  input logic rstN,
  input logic baudTick,
  input logic chrValid,
  input logic chrReady,
  input logic txLine
);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    chrReady |-> txLine);

  p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    (chrValid && chrReady) |=> !chrReady);

  p_line_moves_on_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    !baudTick |=> $stable(txLine));

  p_start_after_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txLine) |-> ($past(baudTick) && !chrReady));

  p_ready_returns_on_tick_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chrReady) |-> ($past(baudTick) && txLine));

endmodule

bind sertx_framer sertx_framer_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .baudTick (baudTick),
  .chrValid (chrValid),
  .chrReady (chrReady),
  .txLine   (txLine)
);

// File: tb/sertx_framer_tb.sv
`timescale 1ns/1ps
module sertx_framer_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       chrValid = 1'b0;
  logic       chrReady;
  logic [7:0] chrData = '0;
  logic       cfgWide = 1'b1;
  logic [2:0] cfgParity = 3'd0;
  logic       cfgTwoStop = 1'b0;
  logic       txLine;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sertx_framer u_dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .chrValid(chrValid),
    .chrReady(chrReady), .chrData(chrData), .cfgWide(cfgWide),
    .cfgParity(cfgParity), .cfgTwoStop(cfgTwoStop), .txLine(txLine)
  );

  task automatic check(input logic ok, input string tag, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic expParity(input logic [7:0] d, input logic wide, input logic [2:0] par);
    logic [7:0] m;
    m = wide ? d : {1'b0, d[6:0]};
    case (par)
      3'd1: return ^m;
      3'd2: return ~(^m);
      3'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string parTag(input logic [2:0] par);
    case (par)
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic runFrame(input logic [7:0] d, input logic wide, input logic [2:0] par,
                          input logic two, input logic tickOnAccept);
    logic [15:0] bits;
    string       tags [16];
    int          n;
    int          w;
    logic        prev;
    logic        expBit;
    bits = '0;
    w = wide ? 8 : 7;
    n = 0;
    bits[n] = 1'b0; tags[n] = "R3"; n++;
    for (int j = 0; j < w; j++) begin
      bits[n] = d[j]; tags[n] = wide ? "R4" : "R5"; n++;
    end
    if (par >= 3'd1 && par <= 3'd4) begin
      bits[n] = expParity(d, wide, par); tags[n] = parTag(par); n++;
    end
    bits[n] = 1'b1; tags[n] = (par == 3'd0) ? "R10" : "R11"; n++;
    if (two) begin
      bits[n] = 1'b1; tags[n] = "R11"; n++;
    end

    @(negedge clk);
    check(chrReady === 1'b1, "R2 ready before offer", chrReady, 1'b1);
    chrData = d; cfgWide = wide; cfgParity = par; cfgTwoStop = two;
    chrValid = 1'b1; baudTick = tickOnAccept;
    @(negedge clk);
    chrValid = 1'b0; baudTick = 1'b0;
    // Scramble the inputs to show that they were latched at acceptance (R2)
    chrData = 8'($urandom); cfgWide = 1'($urandom);
    cfgParity = 3'($urandom % 5); cfgTwoStop = 1'($urandom);
    check(chrReady === 1'b0, "R2 ready after accept", chrReady, 1'b0);
    check(txLine === 1'b1, "R3 line high before first tick", txLine, 1'b1);
    prev = 1'b1;
    for (int i = 0; i <= n; i++) begin
      int gap;
      gap = $urandom % 3;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        check(txLine === prev, "R4 line held between ticks", txLine, prev);
      end
      baudTick = 1'b1;
      @(negedge clk);
      baudTick = 1'b0;
      expBit = (i < n) ? bits[i] : 1'b1;
      check(txLine === expBit, (i < n) ? tags[i] : "R11 idle after frame", txLine, expBit);
      check(chrReady === (i == n), (i == n) ? "R11 ready at frame end" : "R2 busy in frame",
            chrReady, (i == n));
      prev = expBit;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(txLine === 1'b1, "R1 reset line", txLine, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    check(txLine === 1'b1, "R1 idle line", txLine, 1'b1);
    check(chrReady === 1'b1, "R1 idle ready", chrReady, 1'b1);
    for (int k = 0; k < 3; k++) begin
      baudTick = 1'b1;
      @(negedge clk);
      baudTick = 1'b0;
      check(txLine === 1'b1, "R1 idle tick ignored", txLine, 1'b1);
    end

    // Directed corner cases
    runFrame(8'h00, 1'b0, 3'd1, 1'b0, 1'b0);
    runFrame(8'h00, 1'b0, 3'd2, 1'b0, 1'b0);
    runFrame(8'h51, 1'b0, 3'd1, 1'b0, 1'b0);
    runFrame(8'h51, 1'b0, 3'd2, 1'b1, 1'b0);
    runFrame(8'h69, 1'b0, 3'd1, 1'b0, 1'b1);
    runFrame(8'h69, 1'b0, 3'd2, 1'b0, 1'b0);
    runFrame(8'h7F, 1'b0, 3'd1, 1'b1, 1'b0);
    runFrame(8'hD1, 1'b0, 3'd1, 1'b0, 1'b0);
    runFrame(8'h80, 1'b0, 3'd2, 1'b0, 1'b1);
    runFrame(8'hFF, 1'b1, 3'd3, 1'b0, 1'b0);
    runFrame(8'h00, 1'b1, 3'd3, 1'b1, 1'b0);
    runFrame(8'hFF, 1'b1, 3'd4, 1'b0, 1'b0);
    runFrame(8'hA5, 1'b1, 3'd0, 1'b1, 1'b1);
    runFrame(8'h7E, 1'b0, 3'd0, 1'b0, 1'b0);

    // Constrained random frames
    void'($urandom(32'd1357));
    for (int f = 0; f < 60; f++) begin
      runFrame(8'($urandom), 1'($urandom), 3'($urandom % 5), 1'($urandom),
               ($urandom % 4) == 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0b expected=%0b", 1'b0, 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule